// File: doc/BRIEF.md
# Accumulator Pointer Modulo Stepper

This block keeps the 4-bit pointer that chooses which of sixteen accumulators is active. Each time the ALU signals that an arithmetic or logical operation has finished, the pointer can move by one, either up or down. The movement is limited to a window made of the low pointer bits. A 3-bit step-mode field sets the window to 2, 4, 8 or 16 entries, or turns stepping off. The pointer bits above the window never change during a step. This lets software cycle through a small bank of accumulators that starts at any aligned base.

Software controls the block through two write strobes. The pointer write loads a new pointer value. The configuration write loads the step mode and the direction bit. The ALU supplies a one-cycle completion pulse. All inputs are sampled on the rising clock edge. The pointer output comes straight from a register and changes one edge after the input that caused the change. Every pin is a plain control pin, so there is no back-pressure: a completion pulse that arrives while stepping is off has no effect.

Top module: `acc_ptr_stepper`

## Requirements
- R1: While the synchronous reset `rst` is high, the pointer is cleared to 0000, the step mode is cleared to 000 and the direction bit is cleared to 0 (increment).
- R2: With step mode 000, a pulse on `op_done` leaves the pointer unchanged.
- R3: Step mode 001 changes only pointer bit 0, so this bit toggles on each step (modulo 2).
- R4: Step mode 010 steps pointer bits 1:0 modulo 4. For example, 1111 incremented gives 1100.
- R5: Step mode 011 steps pointer bits 2:0 modulo 8. For example, 1111 incremented gives 1000.
- R6: Step mode 100 steps all four pointer bits modulo 16. Codes 101, 110 and 111 behave exactly like 100.
- R7: Direction bit 0 adds one inside the window and direction bit 1 subtracts one inside the window.
- R8: A step never changes pointer bits above the window. For example, mode 001 takes 0111 down to 0110, and mode 010 takes 1100 down to 1111.
- R9: When `ptr_wr_en` and `op_done` are high in the same cycle, the pointer takes `ptr_wr_val` and no step is applied.
- R10: A configuration write takes effect from the next cycle. An `op_done` pulse in the same cycle as the write steps with the mode and direction that were held before the write.
- R11: In a cycle with neither `ptr_wr_en` nor `op_done` high, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ptr_wr_en | input | 1 | Load the pointer from `ptr_wr_val` |
| ptr_wr_val | input | 4 | Value to load into the pointer |
| cfg_wr_en | input | 1 | Load the step mode and direction |
| cfg_wr_mode | input | 3 | New step mode (000 off, 001/010/011 window of 2/4/8 entries, 100 and above 16 entries) |
| cfg_wr_down | input | 1 | New direction: 0 increment, 1 decrement |
| op_done | input | 1 | One-cycle pulse from the ALU when an operation completes |
| acc_ptr | output | 4 | Current active-accumulator pointer |

## Verification
Directed cases start the pointer at values where the window wraps, in both directions and in every mode: 0111, 1100, 1111 and 0000. Each mode has a starting value that separates a correct window mask from one that is one bit too wide or too narrow, and separates frozen upper bits from a plain 4-bit counter. Other cases apply a pointer write and a completion pulse in the same cycle, or a configuration write and a completion pulse in the same cycle, to fix the priority and the timing of R9 and R10. A long random run then mixes all three strobes and all eight mode codes. Every cycle is compared against a reference stepping function, which tests the reserved mode codes and sequences of steps that follow one another directly.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int ACC_PTR_W   = 4;
  localparam int STEP_MODE_W = 3;

  typedef struct packed {
    logic [STEP_MODE_W-1:0] mode;
    logic                   down;
  } step_cfg_t;

  localparam step_cfg_t STEP_CFG_RESET = '{mode: '0, down: 1'b0};
endpackage

// File: rtl/apm_cfg_reg.sv
module apm_cfg_reg
  import apm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [STEP_MODE_W-1:0] wr_mode,
  input  logic                   wr_down,
  output step_cfg_t              cfg
);
  always_ff @(posedge clk) begin
    if (rst)        cfg <= STEP_CFG_RESET;
    else if (wr_en) cfg <= '{mode: wr_mode, down: wr_down};
  end

  // R1: the reset state of the configuration is off / increment
  assert_cfg_reset_R1: assert property (@(posedge clk) rst |=> (cfg.mode == '0 && !cfg.down));
  // R10: a written configuration is visible from the next cycle
  assert_cfg_load_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cfg.mode == $past(wr_mode) && cfg.down == $past(wr_down)));
  // R10: with no write the configuration does not change
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg));
endmodule

// File: rtl/apm_window_dec.sv
module apm_window_dec
  import apm_pkg::*;
#(
  parameter int PTR_W = ACC_PTR_W
) (
  input  logic [STEP_MODE_W-1:0] mode,
  output logic [PTR_W-1:0]       mask
);
  // Bit i belongs to the window once mode exceeds i; codes at or above
  // PTR_W open the whole pointer, which also covers the reserved codes.
  for (genvar i = 0; i < PTR_W; i++) begin : g_bit
    assign mask[i] = (int'(mode) > i);
  end

  always_comb begin
    // R6: the window is always a run of low bits, never a gap
    assert_mask_contig_R6: assert (((mask + 1'b1) & mask) == '0);
    // R2: mode zero opens no window
    assert_mask_off_R2: assert ((mode != '0) || (mask == '0));
  end
endmodule

// File: rtl/apm_step_unit.sv
module apm_step_unit #(
  parameter int PTR_W = 4
) (
  input  logic [PTR_W-1:0] cur,
  input  logic [PTR_W-1:0] mask,
  input  logic             down,
  output logic [PTR_W-1:0] nxt
);
  logic [PTR_W-1:0] moved;

  always_comb begin
    if (down) moved = cur - PTR_W'(1);
    else      moved = cur + PTR_W'(1);
  end

  // Bits inside the window take the moved value; bits above keep theirs.
  // A carry or borrow leaving the window is dropped at the mask edge.
  for (genvar i = 0; i < PTR_W; i++) begin : g_sel
    assign nxt[i] = mask[i] ? moved[i] : cur[i];
  end
endmodule

// File: rtl/acc_ptr_stepper.sv
module acc_ptr_stepper
  import apm_pkg::*;
#(
  parameter int PTR_W = ACC_PTR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ptr_wr_en,
  input  logic [PTR_W-1:0]       ptr_wr_val,
  input  logic                   cfg_wr_en,
  input  logic [STEP_MODE_W-1:0] cfg_wr_mode,
  input  logic                   cfg_wr_down,
  input  logic                   op_done,
  output logic [PTR_W-1:0]       acc_ptr
);
  step_cfg_t        cfg;
  logic [PTR_W-1:0] win_mask;
  logic [PTR_W-1:0] step_val;

  apm_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_mode (cfg_wr_mode),
    .wr_down (cfg_wr_down),
    .cfg     (cfg)
  );

  apm_window_dec #(.PTR_W(PTR_W)) u_win (
    .mode (cfg.mode),
    .mask (win_mask)
  );

  apm_step_unit #(.PTR_W(PTR_W)) u_step (
    .cur  (acc_ptr),
    .mask (win_mask),
    .down (cfg.down),
    .nxt  (step_val)
  );

  // A software load wins over a step in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)            acc_ptr <= '0;
    else if (ptr_wr_en) acc_ptr <= ptr_wr_val;
    else if (op_done)   acc_ptr <= step_val;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (acc_ptr == '0));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ptr_wr_en |=> (acc_ptr == $past(ptr_wr_val)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!ptr_wr_en && !op_done) |=> $stable(acc_ptr));

  assert_off_no_step_R2: assert property (@(posedge clk) disable iff (rst)
    (op_done && !ptr_wr_en && cfg.mode == '0) |=> $stable(acc_ptr));

  assert_upper_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (op_done && !ptr_wr_en) |=> (((acc_ptr ^ $past(acc_ptr)) & ~$past(win_mask)) == '0));

  assert_up_by_one_R7: assert property (@(posedge clk) disable iff (rst)
    (op_done && !ptr_wr_en && !cfg.down) |=>
      (((acc_ptr - $past(acc_ptr)) & $past(win_mask)) == (PTR_W'(1) & $past(win_mask))));

  assert_down_by_one_R7: assert property (@(posedge clk) disable iff (rst)
    (op_done && !ptr_wr_en && cfg.down) |=>
      ((($past(acc_ptr) - acc_ptr) & $past(win_mask)) == (PTR_W'(1) & $past(win_mask))));

  assert_mod2_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (op_done && !ptr_wr_en && cfg.mode == 3'd1) |=> ((acc_ptr ^ $past(acc_ptr)) == PTR_W'(1)));
endmodule

// File: tb/acc_ptr_stepper_bench.sv
module acc_ptr_stepper_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       ptr_wr_en;
  logic [3:0] ptr_wr_val;
  logic       cfg_wr_en;
  logic [2:0] cfg_wr_mode;
  logic       cfg_wr_down;
  logic       op_done;
  logic [3:0] acc_ptr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0] m_ptr;
  logic [2:0] m_mode;
  logic       m_down;

  always #4 clk = ~clk;

  acc_ptr_stepper u_acc_ptr_stepper (
    .clk (clk), .rst (rst),
    .ptr_wr_en (ptr_wr_en), .ptr_wr_val (ptr_wr_val),
    .cfg_wr_en (cfg_wr_en), .cfg_wr_mode (cfg_wr_mode), .cfg_wr_down (cfg_wr_down),
    .op_done (op_done), .acc_ptr (acc_ptr)
  );

  function automatic logic [3:0] ref_step(logic [3:0] p, logic [2:0] mode, logic down);
    int n;
    logic [3:0] msk, mv;
    if (mode == 3'd0) return p;
    n   = (mode >= 3'd4) ? 4 : int'(mode);
    msk = 4'((1 << n) - 1);
    mv  = down ? p - 4'd1 : p + 4'd1;
    return (p & ~msk) | (mv & msk);
  endfunction

  function automatic string mode_tag(logic [2:0] mode);
    case (mode)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    checks++;
    if (acc_ptr !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, acc_ptr, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic cyc(logic pw, logic [3:0] pv, logic cw, logic [2:0] cm, logic cd,
                     logic op, string tag);
    ptr_wr_en = pw; ptr_wr_val = pv; cfg_wr_en = cw;
    cfg_wr_mode = cm; cfg_wr_down = cd; op_done = op;
    @(posedge clk);
    if (pw)      m_ptr = pv;
    else if (op) m_ptr = ref_step(m_ptr, m_mode, m_down);
    if (cw) begin m_mode = cm; m_down = cd; end
    @(negedge clk);
    check(tag, m_ptr);
  endtask

  task automatic load(logic [3:0] p, logic [2:0] mode, logic down);
    cyc(1'b1, p, 1'b1, mode, down, 1'b0, "R9");
  endtask

  task automatic step(string tag);
    cyc(1'b0, 4'd0, 1'b0, 3'd0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    rst = 1'b1; ptr_wr_en = 0; ptr_wr_val = 0; cfg_wr_en = 0;
    cfg_wr_mode = 0; cfg_wr_down = 0; op_done = 0;
    m_ptr = 0; m_mode = 0; m_down = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 4'b0000);
    rst = 1'b0;
    // R1: after reset the mode is off, so a step does nothing
    step("R1 mode off after reset");
    // R2
    load(4'b1010, 3'd0, 1'b0); step("R2"); step("R2");
    // R3 / R8
    load(4'b0111, 3'd1, 1'b1); step("R8 R3 0111->0110");
    step("R3 back to 0111");
    // R4 / R8
    load(4'b1100, 3'd2, 1'b1); step("R8 R4 1100->1111");
    load(4'b1111, 3'd2, 1'b0); step("R4 1111->1100");
    // R5
    load(4'b0111, 3'd3, 1'b0); step("R5 0111->0000");
    load(4'b1111, 3'd3, 1'b0); step("R5 1111->1000");
    load(4'b1000, 3'd3, 1'b1); step("R5 1000->1111");
    // R6 including reserved codes
    load(4'b1111, 3'd4, 1'b0); step("R6 1111->0000");
    load(4'b0000, 3'd7, 1'b1); step("R6 reserved 0000->1111");
    load(4'b0111, 3'd5, 1'b0); step("R6 reserved 0111->1000");
    load(4'b1000, 3'd6, 1'b1); step("R6 reserved 1000->0111");
    // R7
    load(4'b0101, 3'd4, 1'b0); step("R7 up"); step("R7 up");
    load(4'b0101, 3'd4, 1'b1); step("R7 down"); step("R7 down");
    // R9
    load(4'b0011, 3'd4, 1'b0);
    cyc(1'b1, 4'b1001, 1'b0, 3'd0, 1'b0, 1'b1, "R9 write beats step");
    // R10: config write with op in the same cycle uses old settings
    cyc(1'b0, 4'd0, 1'b1, 3'd1, 1'b1, 1'b1, "R10 old config used");
    step("R10 new config used");
    // R11
    cyc(1'b0, 4'd0, 1'b0, 3'd0, 1'b0, 1'b0, "R11 hold");
    cyc(1'b0, 4'd0, 1'b1, 3'd4, 1'b0, 1'b0, "R11 hold on cfg write");
    // Random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic pw, cw, op, cd;
      logic [3:0] pv;
      logic [2:0] cm;
      string tag;
      pw = ($urandom % 8) == 0;
      cw = ($urandom % 6) == 0;
      op = ($urandom % 2) == 0;
      pv = 4'($urandom);
      cm = 3'($urandom);
      cd = 1'($urandom);
      if (pw)      tag = "R9 random";
      else if (op) tag = {mode_tag(m_mode), m_down ? " R7 dn random" : " R7 up random"};
      else         tag = "R11 random";
      cyc(pw, pv, cw, cm, cd, op, tag);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule